// File: doc/BRIEF.md
# Graphics Command Stream Packet Parser

The parser takes a graphics command stream one byte at a time over a valid/ready handshake. It splits the stream into variable-length packets, each led by a one-byte opcode. Register-load packets become single-cycle write strobes, with address and data, into one of three register spaces: the blit unit, the command-processor unit and the transform unit. Indexed-load, display-list-call and vertex-cache-invalidate packets each drive a separate request output. Multi-byte fields arrive most-significant byte first.

A transform-unit packet carries a 32-bit header. The header holds a start address and a count, and the data words that follow are written to consecutive addresses. The caller's register files may stall a pending write; the parser then holds the strobe and refuses input until the stall clears. The parser does not fetch memory for indexed loads or display lists, and it holds no registers of its own.

Top module: `gfx_cmd_parser`

## Requirements
- R1: While reset is asserted, all strobes, request pulses and the error flag are low and `in_ready` is low. Two clock edges after reset is released, `in_ready` is high and the next byte accepted is treated as an opcode.
- R2: Opcode 0x00 consumes one byte and produces no output.
- R3: Opcode 0x61 is followed by one 32-bit word. Bits 31:24 go to `bp_addr` and bits 23:0 to `bp_data`, with `bp_we` high.
- R4: Opcode 0x08 is followed by one address byte (`cp_addr`) and then one 32-bit word (`cp_data`), with `cp_we` high.
- R5: Opcode 0x10 is followed by a header word. Bits 15:0 are the start address and bits 31:16 are a count N. N+1 data words follow. Word k is written with `xf_we` to address start+k, which wraps modulo 2^16. There is one strobe per word.
- R6: Opcodes 0x20, 0x28, 0x30 and 0x38 are each followed by one word. They raise `idx_req` with `idx_sel` equal to opcode bits 4:3 (0 to 3). The fields are `idx_dest`=bits 31:20, `idx_cnt`=bits 19:16 and `idx_index`=bits 15:0.
- R7: Opcode 0x40 is followed by two words. It raises `call_req` for one cycle with `call_addr` set to the first word and `call_len` set to the second.
- R8: Opcode 0x48 consumes one byte and pulses `inval` for one cycle.
- R9: Any other opcode byte sets `err`, which stays set until reset. The byte is skipped, and the next byte is taken as an opcode.
- R10: When a write strobe (`bp_we`, `cp_we`, `xf_we`) is high and `stall` is high, the strobe and its address and data are held on the next cycle. `in_ready` is low exactly in this case, once reset has been released.
- R11: Payload bytes are never decoded as opcodes, even when their values equal an opcode.
- R12: Every strobe or request rises on the cycle after the packet's final byte is accepted. If it is not stalled, it lasts one cycle, and at most one strobe or request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Parser accepts a byte |
| stall | input | 1 | Downstream cannot take a register write |
| bp_we | output | 1 | Blit-unit write strobe |
| bp_addr | output | 8 | Blit-unit register address |
| bp_data | output | 24 | Blit-unit write value |
| cp_we | output | 1 | Command-processor write strobe |
| cp_addr | output | 8 | Command-processor register address |
| cp_data | output | 32 | Command-processor write value |
| xf_we | output | 1 | Transform-unit write strobe |
| xf_addr | output | 16 | Transform-unit address |
| xf_data | output | 32 | Transform-unit write value |
| idx_req | output | 1 | Indexed-load request pulse |
| idx_sel | output | 2 | Indexed-load variant 0 to 3 |
| idx_dest | output | 12 | Indexed-load destination |
| idx_cnt | output | 4 | Indexed-load element count |
| idx_index | output | 16 | Indexed-load array index |
| call_req | output | 1 | Display-list call pulse |
| call_addr | output | 32 | Display-list address |
| call_len | output | 32 | Display-list byte length |
| inval | output | 1 | Vertex-cache invalidate pulse |
| err | output | 1 | Sticky unknown-opcode flag |

## Verification
The assertions check the invariants on every cycle:
- a stalled write holds its strobe and its address and data;
- `in_ready` falls only under a stalled write;
- at most one output strobe is high at a time;
- the error flag never clears outside reset;
- a call request never lasts two cycles.

The field extraction needs the bench's scenarios, because correctness there depends on the packet content. These scenarios cover:
- the transform burst's address sequence and its wrap at 0xFFFF;
- the mapping from opcode to indexed-load variant;
- payload bytes that mimic opcodes;
- back-to-back invalidates;
- recovery after an unknown opcode;
- a reset in the middle of a packet.

The bench's model follows each packet from its bytes and compares the outputs every cycle, with and without a pseudo-random stall.

// File: rtl/gcp_pkg.sv
package gcp_pkg;
  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_BLIT  = 8'h61;
  localparam logic [7:0] OP_CPLD  = 8'h08;
  localparam logic [7:0] OP_XFLD  = 8'h10;
  localparam logic [7:0] OP_IDXA  = 8'h20;
  localparam logic [7:0] OP_IDXB  = 8'h28;
  localparam logic [7:0] OP_IDXC  = 8'h30;
  localparam logic [7:0] OP_IDXD  = 8'h38;
  localparam logic [7:0] OP_CALL  = 8'h40;
  localparam logic [7:0] OP_INVAL = 8'h48;

  typedef enum logic [3:0] {
    ST_OP, ST_CPADR, ST_BP, ST_CP, ST_XHDR, ST_XDAT, ST_IDX, ST_CADR, ST_CLEN
  } pst_e;
endpackage

// File: rtl/gcp_rst_sync.sv
module gcp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      s1    <= 1'b1;
      rst_q <= s1;
    end
  end
endmodule

// File: rtl/gcp_opdec.sv
module gcp_opdec
  import gcp_pkg::*;
(
  input  logic [7:0] op,
  output pst_e       nxt,
  output logic       known,
  output logic       is_inval
);
  always_comb begin
    nxt      = ST_OP;
    known    = 1'b1;
    is_inval = 1'b0;
    case (op)
      OP_NOP:   nxt = ST_OP;
      OP_BLIT:  nxt = ST_BP;
      OP_CPLD:  nxt = ST_CPADR;
      OP_XFLD:  nxt = ST_XHDR;
      OP_IDXA, OP_IDXB, OP_IDXC, OP_IDXD: nxt = ST_IDX;
      OP_CALL:  nxt = ST_CADR;
      OP_INVAL: is_inval = 1'b1;
      default:  known = 1'b0;
    endcase
  end
endmodule

// File: rtl/gcp_word_asm.sv
module gcp_word_asm #(
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [7:0]      byte_in,
  output logic [8*NB-1:0] word,
  output logic            done
);
  localparam int CW = $clog2(NB);
  localparam int SW = 8 * (NB - 1);

  logic [SW-1:0] sh, sh_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    done  = take && (cnt == CW'(NB - 1));
    word  = {sh, byte_in};
    sh_n  = sh;
    cnt_n = cnt;
    if (take) begin
      sh_n  = {sh[SW-9:0], byte_in};
      cnt_n = done ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (take) begin
      sh  <= sh_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/gfx_cmd_parser.sv
module gfx_cmd_parser
  import gcp_pkg::*;
#(
  parameter int XF_AW = 16,
  parameter int XF_CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  input  logic              stall,
  output logic              bp_we,
  output logic [7:0]        bp_addr,
  output logic [23:0]       bp_data,
  output logic              cp_we,
  output logic [7:0]        cp_addr,
  output logic [31:0]       cp_data,
  output logic              xf_we,
  output logic [XF_AW-1:0]  xf_addr,
  output logic [31:0]       xf_data,
  output logic              idx_req,
  output logic [1:0]        idx_sel,
  output logic [11:0]       idx_dest,
  output logic [3:0]        idx_cnt,
  output logic [15:0]       idx_index,
  output logic              call_req,
  output logic [31:0]       call_addr,
  output logic [31:0]       call_len,
  output logic              inval,
  output logic              err
);
  localparam int LW = XF_CW + 1;

  logic rst_q;
  gcp_rst_sync u_rs (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  pst_e st, st_n;
  logic [LW-1:0]    left, left_n;
  logic [XF_AW-1:0] ptr, ptr_n;

  logic blocked, acc, take, wdone;
  logic [31:0] w;
  pst_e dec_nxt;
  logic dec_known, dec_inval;

  logic bp_we_n, cp_we_n, xf_we_n, idx_req_n, call_req_n, inval_n, err_n;
  logic [7:0]       bp_addr_n, cp_addr_n;
  logic [23:0]      bp_data_n;
  logic [31:0]      cp_data_n, xf_data_n, call_addr_n, call_len_n;
  logic [XF_AW-1:0] xf_addr_n;
  logic [1:0]       idx_sel_n;
  logic [11:0]      idx_dest_n;
  logic [3:0]       idx_cnt_n;
  logic [15:0]      idx_index_n;

  assign blocked  = (bp_we | cp_we | xf_we) & stall;
  assign in_ready = rst_q & ~blocked;
  assign acc      = in_valid & in_ready;
  assign take     = acc & (st != ST_OP) & (st != ST_CPADR);

  gcp_opdec u_dec (.op(in_byte), .nxt(dec_nxt), .known(dec_known), .is_inval(dec_inval));

  gcp_word_asm #(.NB(4)) u_asm (
    .clk(clk), .rst_n(rst_q), .take(take), .byte_in(in_byte), .word(w), .done(wdone)
  );

  always_comb begin
    st_n = st; left_n = left; ptr_n = ptr;
    bp_we_n = blocked & bp_we;
    cp_we_n = blocked & cp_we;
    xf_we_n = blocked & xf_we;
    idx_req_n = 1'b0; call_req_n = 1'b0; inval_n = 1'b0; err_n = err;
    bp_addr_n = bp_addr; bp_data_n = bp_data;
    cp_addr_n = cp_addr; cp_data_n = cp_data;
    xf_addr_n = xf_addr; xf_data_n = xf_data;
    idx_sel_n = idx_sel; idx_dest_n = idx_dest; idx_cnt_n = idx_cnt; idx_index_n = idx_index;
    call_addr_n = call_addr; call_len_n = call_len;
    if (acc) begin
      case (st)
        ST_OP: begin
          st_n      = dec_nxt;
          inval_n   = dec_inval;
          err_n     = err | ~dec_known;
          idx_sel_n = in_byte[4:3];
        end
        ST_CPADR: begin
          cp_addr_n = in_byte;
          st_n      = ST_CP;
        end
        default: begin
          if (wdone) begin
            case (st)
              ST_BP: begin
                bp_we_n = 1'b1; bp_addr_n = w[31:24]; bp_data_n = w[23:0]; st_n = ST_OP;
              end
              ST_CP: begin
                cp_we_n = 1'b1; cp_data_n = w; st_n = ST_OP;
              end
              ST_XHDR: begin
                ptr_n  = w[XF_AW-1:0];
                left_n = {1'b0, w[16 +: XF_CW]} + 1'b1;
                st_n   = ST_XDAT;
              end
              ST_XDAT: begin
                xf_we_n = 1'b1; xf_addr_n = ptr; xf_data_n = w;
                ptr_n   = ptr + 1'b1;
                left_n  = left - 1'b1;
                if (left == LW'(1)) st_n = ST_OP;
              end
              ST_IDX: begin
                idx_req_n = 1'b1; idx_dest_n = w[31:20]; idx_cnt_n = w[19:16];
                idx_index_n = w[15:0]; st_n = ST_OP;
              end
              ST_CADR: begin
                call_addr_n = w; st_n = ST_CLEN;
              end
              ST_CLEN: begin
                call_req_n = 1'b1; call_len_n = w; st_n = ST_OP;
              end
              default: st_n = ST_OP;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st <= ST_OP; left <= '0; ptr <= '0;
      bp_we <= 1'b0; cp_we <= 1'b0; xf_we <= 1'b0;
      idx_req <= 1'b0; call_req <= 1'b0; inval <= 1'b0; err <= 1'b0;
      bp_addr <= '0; bp_data <= '0; cp_addr <= '0; cp_data <= '0;
      xf_addr <= '0; xf_data <= '0;
      idx_sel <= '0; idx_dest <= '0; idx_cnt <= '0; idx_index <= '0;
      call_addr <= '0; call_len <= '0;
    end else begin
      st <= st_n; left <= left_n; ptr <= ptr_n;
      bp_we <= bp_we_n; cp_we <= cp_we_n; xf_we <= xf_we_n;
      idx_req <= idx_req_n; call_req <= call_req_n; inval <= inval_n; err <= err_n;
      bp_addr <= bp_addr_n; bp_data <= bp_data_n; cp_addr <= cp_addr_n; cp_data <= cp_data_n;
      xf_addr <= xf_addr_n; xf_data <= xf_data_n;
      idx_sel <= idx_sel_n; idx_dest <= idx_dest_n; idx_cnt <= idx_cnt_n; idx_index <= idx_index_n;
      call_addr <= call_addr_n; call_len <= call_len_n;
    end
  end

  // R10: a stalled write keeps its strobe, address and data
  a_r10_hold_bp: assert property (@(posedge clk) disable iff (!rst_q)
    (bp_we && stall) |=> (bp_we && $stable(bp_addr) && $stable(bp_data)));
  a_r10_hold_cp: assert property (@(posedge clk) disable iff (!rst_q)
    (cp_we && stall) |=> (cp_we && $stable(cp_addr) && $stable(cp_data)));
  a_r10_hold_xf: assert property (@(posedge clk) disable iff (!rst_q)
    (xf_we && stall) |=> (xf_we && $stable(xf_addr) && $stable(xf_data)));
  // R10: ready falls only under a stalled write
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_q)
    !in_ready |-> ((bp_we || cp_we || xf_we) && stall));
  // R12: at most one output strobe at a time; call pulse is single-cycle
  a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({bp_we, cp_we, xf_we, idx_req, call_req, inval}));
  a_r12_call_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    call_req |=> !call_req);
  // R9: error flag is sticky
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_q)
    err |=> err);
endmodule

// File: tb/sim_gfx_cmd_parser.sv
module sim_gfx_cmd_parser;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_ready, stall;
  logic [7:0] in_byte;
  logic bp_we, cp_we, xf_we, idx_req, call_req, inval, err;
  logic [7:0] bp_addr, cp_addr;
  logic [23:0] bp_data;
  logic [31:0] cp_data, xf_data, call_addr, call_len;
  logic [15:0] xf_addr, idx_index;
  logic [1:0] idx_sel;
  logic [11:0] idx_dest;
  logic [3:0] idx_cnt;

  gfx_cmd_parser u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .stall(stall), .bp_we(bp_we), .bp_addr(bp_addr), .bp_data(bp_data),
    .cp_we(cp_we), .cp_addr(cp_addr), .cp_data(cp_data),
    .xf_we(xf_we), .xf_addr(xf_addr), .xf_data(xf_data),
    .idx_req(idx_req), .idx_sel(idx_sel), .idx_dest(idx_dest), .idx_cnt(idx_cnt),
    .idx_index(idx_index), .call_req(call_req), .call_addr(call_addr), .call_len(call_len),
    .inval(inval), .err(err)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // stall generator
  logic stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    stall <= stall_en & lfsr[0] & lfsr[3];
  end
  initial stall = 1'b0;

  // behavioural reference model
  logic [7:0] q[$];
  int  m_sync;
  bit  m_bp, m_cp, m_xf, m_idx, m_call, m_inv, m_err, m_blk;
  logic [7:0] m_bpa, m_cpa;
  logic [23:0] m_bpd;
  logic [31:0] m_cpd, m_xfd, m_ca, m_cl;
  logic [15:0] m_xfa, m_ii;
  logic [1:0] m_is;
  logic [11:0] m_id;
  logic [3:0] m_ic;

  function automatic logic [31:0] qword(input int i);
    return {q[i], q[i+1], q[i+2], q[i+3]};
  endfunction

  task automatic model_byte();
    int n, k, sz, st;
    logic [31:0] wv;
    n = q.size();
    case (q[0])
      8'h00: q.delete();
      8'h48: begin m_inv = 1; q.delete(); end
      8'h61: if (n == 5) begin
        wv = qword(1); m_bp = 1; m_bpa = wv[31:24]; m_bpd = wv[23:0]; q.delete();
      end
      8'h08: if (n == 6) begin
        m_cp = 1; m_cpa = q[1]; m_cpd = qword(2); q.delete();
      end
      8'h10: if (n >= 9 && ((n - 5) % 4) == 0) begin
        sz = {q[1], q[2]}; st = {q[3], q[4]}; k = (n - 9) / 4;
        m_xf = 1; m_xfa = 16'(st + k); m_xfd = qword(n - 4);
        if (k == sz) q.delete();
      end
      8'h20, 8'h28, 8'h30, 8'h38: if (n == 5) begin
        wv = qword(1); m_idx = 1; m_is = 2'((q[0] - 8'h20) / 8);
        m_id = wv[31:20]; m_ic = wv[19:16]; m_ii = wv[15:0]; q.delete();
      end
      8'h40: if (n == 9) begin
        m_call = 1; m_ca = qword(1); m_cl = qword(5); q.delete();
      end
      default: begin m_err = 1; q.delete(); end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_sync = 0;
      m_bp = 0; m_cp = 0; m_xf = 0; m_idx = 0; m_call = 0; m_inv = 0; m_err = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      m_blk = (m_bp | m_cp | m_xf) & stall;
      if (!m_blk) begin m_bp = 0; m_cp = 0; m_xf = 0; end
      m_idx = 0; m_call = 0; m_inv = 0;
      if (in_valid && !m_blk) begin
        q.push_back(in_byte);
        model_byte();
      end
    end
  end

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (!finished) begin
      chk("R10 ready", in_ready, (m_sync == 2) && !((m_bp | m_cp | m_xf) && stall));
      chk("R3 blit strobe", bp_we, m_bp);
      if (m_bp) chk("R3 blit addr/data", {bp_addr, bp_data}, {m_bpa, m_bpd});
      chk("R4 cp strobe", cp_we, m_cp);
      if (m_cp) chk("R4 cp addr/data", {cp_addr, cp_data}, {m_cpa, m_cpd});
      chk("R5 xf strobe", xf_we, m_xf);
      if (m_xf) chk("R5 xf addr/data", {xf_addr, xf_data}, {m_xfa, m_xfd});
      chk("R6 idx strobe", idx_req, m_idx);
      if (m_idx) chk("R6 idx fields", {idx_sel, idx_dest, idx_cnt, idx_index}, {m_is, m_id, m_ic, m_ii});
      chk("R7 call strobe", call_req, m_call);
      if (m_call) chk("R7 call fields", {call_addr, call_len}, {m_ca, m_cl});
      chk("R8 R11 inval", inval, m_inv);
      chk("R9 err", err, m_err);
    end
  end

  task automatic send_byte(input logic [7:0] b);
    logic ok;
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    forever begin
      #1;
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[8*i +: 8]);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    send_byte(8'h00);                                   // R2
    send_byte(8'h61); send_word(32'h4848_0048);         // R3, R11
    send_byte(8'h08); send_byte(8'h3A); send_word(32'hDEAD_BEEF); // R4
    send_byte(8'h10); send_word({16'd2, 16'h0400});     // R5
    send_word(32'h1111_0001); send_word(32'h2222_0002); send_word(32'h3333_0003);
    send_byte(8'h10); send_word({16'd1, 16'hFFFF});     // R5 wrap
    send_word(32'hAAAA_5555); send_word(32'h0F0F_F0F0);
    send_byte(8'h20); send_word(32'hABC5_1234);         // R6
    send_byte(8'h28); send_word(32'h0017_FFFF);
    send_byte(8'h30); send_word(32'hFFF0_0000);
    send_byte(8'h38); send_word(32'h123F_4040);
    send_byte(8'h40); send_word(32'h8000_1000); send_word(32'h0000_0200); // R7
    send_byte(8'h48); send_byte(8'h48);                 // R8 back to back
    idle(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 ready in reset", in_ready, 1'b0);
    chk("R1 strobes in reset", {bp_we, cp_we, xf_we, idx_req, call_req, inval, err}, 7'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 ready after release", in_ready, 1'b1);

    run_all();
    send_byte(8'h77);                                   // R9 unknown
    idle(2); #2;
    chk("R9 err set", err, 1'b1);
    send_byte(8'h61); send_word(32'h0102_0304);         // R9 next byte is opcode
    idle(2); #2;
    chk("R9 err sticky", err, 1'b1);

    stall_en = 1'b1;                                    // R10
    run_all();
    run_all();
    stall_en = 1'b0;
    idle(3);

    send_byte(8'h61); send_byte(8'h11);                 // reset mid-packet
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    #2;
    chk("R9 err cleared by reset", err, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_byte(8'h61); send_word(32'hFE00_0001);         // R1 opcode after reset
    idle(3);
    run_all();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule